// File: doc/BRIEF.md
# Coincident-Current Core Plane Model

This block is a cycle-level, synthesizable stand-in for one bit-plane of magnetic core memory. Each storage cell holds one bit. A cell changes state only when the net drive current through it reaches the switching threshold. Currents are counted in quarter-threshold units. Each selected X or Y wire carries half the threshold (2 units). The drive direction decides the sign: a read drives toward zero and a write drives toward one. During a write, an inhibit current of 2 units opposes the drive.

A normal access selects one X wire and one Y wire. Only the cell at their crossing sees 4 units and can switch. Every other cell on either wire sees 2 units and keeps its value. A read therefore clears the addressed cell. If that cell held a one, a single shared sense output pulses. A write sets the cell unless inhibit is raised. The usual pattern is a read followed by a write, with inhibit chosen from the bit to be restored. The select inputs are not forced to be one-hot: several wires may be driven at once, and the same threshold rule then applies at every crossing.

Top module: `core_plane`

## Requirements
- R1: An active-low reset clears every cell to zero and drives senseOut low.
- R2: With driveEn high and exactly one X and one Y wire selected, a read (writeDir=0) leaves the crossing cell at zero, and a write (writeDir=1) with inhibit low leaves it at one.
- R3: A cell whose X wire or Y wire is selected, but not both, never changes state, whatever the direction or inhibit.
- R4: senseOut is registered. It is high in the clock cycle after a read that switches at least one cell from one to zero. It is low after a read of cells that were already zero, and low after writes and idle cycles.
- R5: A write with inhibit high leaves the crossing cell unchanged: a zero stays zero and a one stays one.
- R6: The inhibit input has no effect during a read. A read with inhibit high clears the cell and reports sense exactly as a read with inhibit low.
- R7: With driveEn low, no cell changes state, whatever the select, direction and inhibit inputs.
- R8: When several X and/or Y wires are selected, every crossing of a selected X wire with a selected Y wire follows the rules of R2, R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| driveEn | input | 1 | Drive pulse applied this cycle |
| writeDir | input | 1 | Drive direction: 1 toward one (write), 0 toward zero (read) |
| inhibit | input | 1 | Inhibit current, opposes the write drive |
| xSel | input | X_WIRES (64) | X wire selects, bit i drives column i |
| ySel | input | Y_WIRES (64) | Y wire selects, bit j drives row j |
| senseOut | output | 1 | Registered sense pulse, one cycle after a one-to-zero flip |

## Verification
The bench applies several kinds of select pattern:
- Full selects (one X, one Y) separate cells that should switch from cells that should not.
- X-only and Y-only drives confirm that a half-select current never switches a cell.
- Two X wires driven with one Y wire check that every crossing switches while the rest of the wire is left alone.
- Idle cycles and inhibit in both directions show that inhibit blocks only writes.

Full destructive read sweeps compare every cell against a reference plane. These sweeps catch any disturbance of a cell other than the addressed one.

// File: rtl/core_plane_pkg.sv
package core_plane_pkg;

  // Strobes passed from the drive decoder to the cell array.
  typedef struct packed {
    logic active;     // a drive pulse is applied this cycle
    logic towardOne;  // drive polarity
    logic inhibitOn;  // opposing current applied (writes only)
    logic flipCross;  // cells with both wires selected reach threshold
    logic flipXOnly;  // cells with only their X wire selected reach threshold
    logic flipYOnly;  // cells with only their Y wire selected reach threshold
  } driveStrobes_t;

endpackage

// File: rtl/core_plane_ctrl.sv
module core_plane_ctrl
  import core_plane_pkg::*;
#(
  parameter int HALF_UNITS    = 2,
  parameter int INHIBIT_UNITS = 2,
  parameter int THRESHOLD     = 4
) (
  input  logic          driveEn,
  input  logic          writeDir,
  input  logic          inhibit,
  output driveStrobes_t strobes
);

  localparam int FullUnits = 2 * HALF_UNITS;

  // Net current, in quarter-threshold units, through a cell with the given
  // wire selection, and whether it reaches threshold in the drive direction.
  function automatic logic reaches(input logic xOn, input logic yOn,
                                   input logic toOne, input logic inh);
    int wireSum;
    int net;
    wireSum = (xOn ? HALF_UNITS : 0) + (yOn ? HALF_UNITS : 0);
    if (toOne) begin
      net = wireSum - (inh ? INHIBIT_UNITS : 0);
      return net >= THRESHOLD;
    end
    net = -wireSum;
    return net <= -THRESHOLD;
  endfunction

  logic inhibitApplied;

  always_comb begin
    // Inhibit current is only pulsed in the write half of a cycle.
    inhibitApplied    = driveEn && writeDir && inhibit;
    strobes.active    = driveEn;
    strobes.towardOne = writeDir;
    strobes.inhibitOn = inhibitApplied;
    strobes.flipCross = driveEn && reaches(1'b1, 1'b1, writeDir, inhibitApplied);
    strobes.flipXOnly = driveEn && reaches(1'b1, 1'b0, writeDir, inhibitApplied);
    strobes.flipYOnly = driveEn && reaches(1'b0, 1'b1, writeDir, inhibitApplied);
  end

  // A single wire must stay below threshold for the coincident scheme to work.
  initial begin
    assert (HALF_UNITS < THRESHOLD && FullUnits >= THRESHOLD)
      else $error("core_plane_ctrl: half-select current must be below threshold");
  end

endmodule

// File: rtl/core_plane_array.sv
module core_plane_array
  import core_plane_pkg::*;
#(
  parameter int X_WIRES = 64,
  parameter int Y_WIRES = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  driveStrobes_t      strobes,
  input  logic [X_WIRES-1:0] xSel,
  input  logic [Y_WIRES-1:0] ySel,
  output logic               senseOut
);

  logic [Y_WIRES-1:0][X_WIRES-1:0] cores;
  logic [Y_WIRES-1:0][X_WIRES-1:0] nextCores;
  logic [Y_WIRES-1:0][X_WIRES-1:0] flipMask;
  logic [Y_WIRES-1:0][X_WIRES-1:0] crossMask;
  logic [Y_WIRES-1:0]              rowLost;

  for (genvar row = 0; row < Y_WIRES; row++) begin : g_row
    logic [X_WIRES-1:0] rowSel;
    assign rowSel = {X_WIRES{ySel[row]}};

    assign crossMask[row] = xSel & rowSel;
    assign flipMask[row] =
        (xSel &  rowSel & {X_WIRES{strobes.flipCross}}) |
        (xSel & ~rowSel & {X_WIRES{strobes.flipXOnly}}) |
        (~xSel & rowSel & {X_WIRES{strobes.flipYOnly}});

    assign nextCores[row] = strobes.towardOne ? (cores[row] | flipMask[row])
                                              : (cores[row] & ~flipMask[row]);
    assign rowLost[row] = !strobes.towardOne && (|(cores[row] & flipMask[row]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cores    <= '0;
      senseOut <= 1'b0;
    end else begin
      cores    <= nextCores;
      senseOut <= |rowLost;
    end
  end

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |=> $stable(cores));

  p_read_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && !strobes.towardOne) |=> ((cores & $past(crossMask)) == '0));

  p_write_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && strobes.towardOne && !strobes.inhibitOn)
      |=> ((cores & $past(crossMask)) == $past(crossMask)));

  p_inhibit_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && strobes.towardOne && strobes.inhibitOn) |=> $stable(cores));

  p_sense_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    senseOut |-> $past(strobes.active && !strobes.towardOne));

  p_sense_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.active && !strobes.towardOne)
      |=> (senseOut == (|($past(cores) & $past(crossMask)))));

endmodule

// File: rtl/core_plane.sv
module core_plane
  import core_plane_pkg::*;
#(
  parameter int X_WIRES       = 64,
  parameter int Y_WIRES       = 64,
  parameter int HALF_UNITS    = 2,
  parameter int INHIBIT_UNITS = 2,
  parameter int THRESHOLD     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               driveEn,
  input  logic               writeDir,
  input  logic               inhibit,
  input  logic [X_WIRES-1:0] xSel,
  input  logic [Y_WIRES-1:0] ySel,
  output logic               senseOut
);

  driveStrobes_t strobes;

  core_plane_ctrl #(
    .HALF_UNITS   (HALF_UNITS),
    .INHIBIT_UNITS(INHIBIT_UNITS),
    .THRESHOLD    (THRESHOLD)
  ) u_ctrl (
    .driveEn (driveEn),
    .writeDir(writeDir),
    .inhibit (inhibit),
    .strobes (strobes)
  );

  core_plane_array #(
    .X_WIRES(X_WIRES),
    .Y_WIRES(Y_WIRES)
  ) u_array (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .xSel    (xSel),
    .ySel    (ySel),
    .senseOut(senseOut)
  );

endmodule

// File: tb/sim_core_plane.sv
`timescale 1ns/1ps
module sim_core_plane;

  localparam int XW = 64;
  localparam int YW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          driveEn = 1'b0;
  logic          writeDir = 1'b0;
  logic          inhibit = 1'b0;
  logic [XW-1:0] xSel = '0;
  logic [YW-1:0] ySel = '0;
  logic          senseOut;

  int checks = 0;
  int failures = 0;
  bit refCore [YW][XW];

  always #4 clk = ~clk;   // 125 MHz

  core_plane u0 (
    .clk(clk), .rstN(rstN), .driveEn(driveEn), .writeDir(writeDir),
    .inhibit(inhibit), .xSel(xSel), .ySel(ySel), .senseOut(senseOut)
  );

  // Reference rule: 2 units per selected wire, 2 opposing units of inhibit on
  // writes only, switching at 4 units in the drive direction.
  function automatic bit cellFlips(bit xOn, bit yOn, bit we, bit inh);
    int net;
    net = (xOn ? 2 : 0) + (yOn ? 2 : 0);
    if (we) return (net - (inh ? 2 : 0)) >= 4;
    return net >= 4;
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: senseOut=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Applies one cycle of drive; entered and left just after a falling edge.
  task automatic doOp(input logic [XW-1:0] xv, input logic [YW-1:0] yv,
                      input bit en, input bit we, input bit inh, input string tag);
    bit expSense;
    expSense = 1'b0;
    driveEn = en; writeDir = we; inhibit = inh; xSel = xv; ySel = yv;
    if (en) begin
      for (int j = 0; j < YW; j++) begin
        for (int i = 0; i < XW; i++) begin
          if (cellFlips(xv[i], yv[j], we, inh)) begin
            if (!we && refCore[j][i]) expSense = 1'b1;
            refCore[j][i] = we;
          end
        end
      end
    end
    @(negedge clk);
    check(senseOut, expSense, tag);
    driveEn = 1'b0;
  endtask

  function automatic logic [XW-1:0] xBit(int i);
    logic [XW-1:0] v;
    v = '0; v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [YW-1:0] yBit(int j);
    logic [YW-1:0] v;
    v = '0; v[j] = 1'b1;
    return v;
  endfunction

  task automatic sweep(input string tag);
    for (int j = 0; j < YW; j++)
      for (int i = 0; i < XW; i++)
        doOp(xBit(i), yBit(j), 1'b1, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int j = 0; j < YW; j++)
      for (int i = 0; i < XW; i++)
        refCore[j][i] = 1'b0;
    repeat (3) @(negedge clk);
    check(senseOut, 1'b0, "R1 reset sense");
    rstN = 1'b1;
    @(negedge clk);
    sweep("R1 reset contents");

    // R2 and R4: write, read, re-read
    doOp(xBit(3), yBit(5), 1, 1, 0, "R4 no sense on write");
    doOp(xBit(3), yBit(5), 1, 0, 0, "R2 R4 read of one");
    doOp(xBit(3), yBit(5), 1, 0, 0, "R2 R4 read of cleared cell");
    // R5: inhibit keeps zero and keeps one
    doOp(xBit(7), yBit(7), 1, 1, 1, "R5 inhibited write");
    doOp(xBit(7), yBit(7), 1, 0, 0, "R5 zero kept");
    doOp(xBit(8), yBit(9), 1, 1, 0, "R5 setup");
    doOp(xBit(8), yBit(9), 1, 1, 1, "R5 inhibited write on one");
    doOp(xBit(8), yBit(9), 1, 0, 0, "R5 one kept");
    // R3: half-selects in both directions
    doOp(xBit(10), yBit(10), 1, 1, 0, "R3 setup");
    doOp(xBit(10), '0, 1, 0, 0, "R3 x-only read");
    doOp('0, yBit(10), 1, 0, 1, "R3 y-only read");
    doOp(xBit(11), '0, 1, 1, 0, "R3 x-only write");
    doOp(xBit(10), yBit(10), 1, 0, 0, "R3 one survives half-select");
    doOp(xBit(11), yBit(12), 1, 0, 0, "R3 zero survives half-select");
    // R6: inhibit during read
    doOp(xBit(2), yBit(2), 1, 1, 0, "R6 setup");
    doOp(xBit(2), yBit(2), 1, 0, 1, "R6 read with inhibit");
    doOp(xBit(2), yBit(2), 1, 0, 0, "R6 cleared");
    // R7: no drive
    doOp(xBit(4), yBit(4), 0, 1, 0, "R7 idle");
    doOp(xBit(4), yBit(4), 1, 0, 0, "R7 untouched");
    // R8: two X wires, one Y wire
    doOp(xBit(1) | xBit(2), yBit(4), 1, 1, 0, "R8 multi write");
    doOp(xBit(1), yBit(4), 1, 0, 0, "R8 first crossing");
    doOp(xBit(2), yBit(4), 1, 0, 0, "R8 second crossing");
    doOp(xBit(3), yBit(4), 1, 0, 0, "R8 neighbour");

    for (int n = 0; n < 3000; n++) begin
      int sel;
      int xi;
      int yi;
      bit we;
      bit inh;
      sel = $urandom % 10;
      xi  = $urandom % XW;
      yi  = $urandom % YW;
      we  = 1'($urandom % 2);
      inh = (($urandom % 4) == 0);
      case (sel)
        5:       doOp(xBit(xi), '0, 1, we, inh, "R3 random x-only");
        6:       doOp('0, yBit(yi), 1, we, inh, "R3 random y-only");
        7:       doOp(xBit(xi) | xBit((xi + 7) % XW), yBit(yi), 1, we, inh, "R8 random multi");
        8:       doOp(xBit(xi), yBit(yi), 0, we, inh, "R7 random idle");
        default: doOp(xBit(xi), yBit(yi), 1, we, inh, "R2 R4 R5 R6 random");
      endcase
    end
    sweep("R3 final sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule